// File: doc/BRIEF.md
# Single-Transfer AHB Bus Master with Handshake Core Channels

This block lets a core that knows nothing about the bus start single AHB transfers. The core hands over a command: an address and a direction. For a write it also hands over one data word. The block then requests the bus, waits for the grant and runs one NONSEQ transfer of burst type SINGLE. It sits through any wait states the slave inserts. When the slave asks for a retry, it issues the same transfer again.

Each core-side exchange uses its own valid/acknowledge pair. Four channels exist: command, write data, read data and final response. Three one-cycle status flags tell the core how each bus attempt ended: completed, failed, or bounced back for a retry. The block takes a new command only when no earlier read data or response is still waiting for the core. Only one transfer is ever in flight.

Top module: `ahb_cmd_master`

## Requirements
- R1: While reset is high, and on the first cycle after it, the block drives: HTRANS IDLE (00), HBUSREQ low, HWDATA zero, and every acknowledge, valid and status output low.
- R2: A command is taken only when three things hold: the block is idle, cmd_valid is high, and both return channels are empty. cmd_latched is high for exactly the one cycle after the clock edge that took the command. cmd_valid has no effect at any other time.
- R3: For a write, the block pulses wdata_latched once when it takes the data word. The bus request is not raised before that. wdata_valid has no effect when no write is waiting for its data.
- R4: HBUSREQ rises on the edge that takes the command (read) or the write data (write). The address phase (HTRANS NONSEQ) starts the cycle after an edge that samples both HGRANT and HREADY high. HBUSREQ falls on the edge that accepts the address phase.
- R5: HTRANS only ever takes the values IDLE (00) and NONSEQ (10), and each attempt makes exactly one NONSEQ phase. HBURST is SINGLE (000) and HPROT equals the PROT_VAL parameter. HTRANS, HADDR and HWRITE hold steady while HREADY is low during the address phase.
- R6: HWDATA carries the captured write word from the cycle after the address phase is accepted until the edge where the data phase completes. It stays stable through wait states and is zero at every other time, including during reads.
- R7: On a read that completes OKAY, rdata_valid rises with the HRDATA value sampled on the completing edge (HREADY high). Both are held until the core pulses rdata_latched.
- R8: A transfer that ends OKAY or ERROR raises resp_valid. The response code is 00 for OKAY and 01 for ERROR. It is held until the core pulses resp_latched. The two return channels drain independently of each other.
- R9: Each status flag is high for one cycle, the cycle after the completing edge. mready marks OKAY, merror marks ERROR, and mretry marks RETRY (10) or SPLIT (11). At most one flag is high at a time.
- R10: When a data phase completes with RETRY or SPLIT, the block presents no response and no read data to the core. It raises HBUSREQ again on that same edge and reissues the same address, direction and write word.
- R11: When a data phase completes with ERROR, the block presents no read data. It makes no further attempt: HBUSREQ stays low and HTRANS stays IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (HCLK) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Core offers a command |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | Command direction, 1 = write |
| cmd_latched | output | 1 | One-cycle acknowledge of a taken command |
| wdata_valid | input | 1 | Core offers the write word |
| wdata | input | DATA_W | Write word |
| wdata_latched | output | 1 | One-cycle acknowledge of the write word |
| rdata_valid | output | 1 | Read data is waiting for the core |
| rdata | output | DATA_W | Read data |
| rdata_latched | input | 1 | Core takes the read data |
| resp_valid | output | 1 | Final response is waiting for the core |
| response | output | 2 | Final response code (00 OKAY, 01 ERROR) |
| resp_latched | input | 1 | Core takes the response |
| mready | output | 1 | Pulse: attempt ended OKAY |
| merror | output | 1 | Pulse: attempt ended ERROR |
| mretry | output | 1 | Pulse: attempt ended RETRY or SPLIT |
| hbusreq | output | 1 | Bus request to the arbiter |
| hgrant | input | 1 | Grant from the arbiter |
| htrans | output | 2 | Transfer type |
| haddr | output | ADDR_W | Transfer address |
| hwrite | output | 1 | Transfer direction |
| hburst | output | 3 | Burst type, fixed SINGLE |
| hprot | output | 4 | Protection attributes, fixed |
| hwdata | output | DATA_W | Write data bus |
| hready | input | 1 | Transfer ready from the slave |
| hresp | input | 2 | Slave response |
| hrdata | input | DATA_W | Read data bus |

## Verification
Suppose the sequencer is in the wrong state. The port-level symptom usually appears within one cycle:
- a NONSEQ phase without a grant;
- a second NONSEQ in the same attempt;
- HWDATA nonzero outside the data phase;
- a request that stays high after the address is accepted.

The bench walks transfers with different grant delays, address-phase stalls, data-phase wait states and outcomes. It checks the bus and core outputs on every cycle of each phase.

A wrong outcome decode is visible on the first cycle after the completing edge. It shows up as the wrong status pulse, a response where a reissue was due, or read data latched from a wait-state cycle (the bench drives dummy HRDATA during wait states).

A stuck return channel shows up as a command that is never acknowledged. A channel that clears early shows up as a valid that drops before the core acknowledges it.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    RS_OKAY  = 2'b00,
    RS_ERROR = 2'b01,
    RS_RETRY = 2'b10,
    RS_SPLIT = 2'b11
  } hresp_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WDAT = 3'd1,
    ST_REQ  = 3'd2,
    ST_ADDR = 3'd3,
    ST_DATA = 3'd4
  } mst_state_e;

endpackage

// File: rtl/ahbm_cmd_stage.sv
module ahbm_cmd_stage #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_cmd,
  input  logic              take_wd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] wdata,
  output logic              cmd_latched,
  output logic              wdata_latched,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_write,
  output logic [DATA_W-1:0] cur_wdata
);

  // Holding registers for the command in flight; kept across reissues.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_latched   <= 1'b0;
      wdata_latched <= 1'b0;
      cur_addr      <= '0;
      cur_write     <= 1'b0;
      cur_wdata     <= '0;
    end else begin
      cmd_latched   <= take_cmd;
      wdata_latched <= take_wd;
      if (take_cmd) begin
        cur_addr  <= cmd_addr;
        cur_write <= cmd_write;
      end
      if (take_wd) begin
        cur_wdata <= wdata;
      end
    end
  end

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_latched |=> !cmd_latched); // R2

  AST_WD_PULSE: assert property (@(posedge clk) disable iff (rst)
    wdata_latched |=> !wdata_latched); // R3

endmodule

// File: rtl/ahbm_bus_fsm.sv
module ahbm_bus_fsm
  import ahbm_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [3:0]  PROT_VAL = 4'b0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              wdata_valid,
  input  logic              ret_busy,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_write,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic              hgrant,
  input  logic              hready,
  input  logic [1:0]        hresp,
  output logic              take_cmd,
  output logic              take_wd,
  output logic              fin_ok,
  output logic              fin_err,
  output logic              fin_again,
  output logic              hbusreq,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hburst,
  output logic [3:0]        hprot,
  output logic [DATA_W-1:0] hwdata
);

  mst_state_e state_q;
  logic       data_end;

  assign take_cmd  = (state_q == ST_IDLE) && cmd_valid && !ret_busy;
  assign take_wd   = (state_q == ST_WDAT) && wdata_valid;
  assign data_end  = (state_q == ST_DATA) && hready;
  assign fin_ok    = data_end && (hresp == RS_OKAY);
  assign fin_err   = data_end && (hresp == RS_ERROR);
  assign fin_again = data_end && ((hresp == RS_RETRY) || (hresp == RS_SPLIT));

  assign hburst = BURST_SINGLE;
  assign hprot  = PROT_VAL;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hbusreq <= 1'b0;
      htrans  <= TR_IDLE;
      haddr   <= '0;
      hwrite  <= 1'b0;
      hwdata  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_cmd) begin
            if (cmd_write) begin
              state_q <= ST_WDAT;
            end else begin
              state_q <= ST_REQ;
              hbusreq <= 1'b1;
            end
          end
        end
        ST_WDAT: begin
          if (take_wd) begin
            state_q <= ST_REQ;
            hbusreq <= 1'b1;
          end
        end
        ST_REQ: begin
          // Ownership of the address bus starts after grant with HREADY high.
          if (hgrant && hready) begin
            state_q <= ST_ADDR;
            htrans  <= TR_NONSEQ;
            haddr   <= cur_addr;
            hwrite  <= cur_write;
          end
        end
        ST_ADDR: begin
          if (hready) begin
            state_q <= ST_DATA;
            htrans  <= TR_IDLE;
            hbusreq <= 1'b0;
            hwdata  <= cur_write ? cur_wdata : '0;
          end
        end
        ST_DATA: begin
          if (hready) begin
            hwdata <= '0;
            if (fin_again) begin
              state_q <= ST_REQ;
              hbusreq <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_TRANS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_IDLE) || (htrans == TR_NONSEQ)); // R5

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ && !hready) |=>
      (htrans == TR_NONSEQ && $stable(haddr) && $stable(hwrite))); // R5

  AST_SINGLE_NONSEQ: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ && hready) |=> (htrans == TR_IDLE)); // R5

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && !hready) |=> $stable(hwdata)); // R6

  AST_WDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ) |-> (hwdata == '0)); // R6

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(hbusreq) |-> $past(htrans == TR_NONSEQ && hready)); // R4

endmodule

// File: rtl/ahbm_ret_chan.sv
module ahbm_ret_chan
  import ahbm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin_ok,
  input  logic              fin_err,
  input  logic              fin_again,
  input  logic              fin_read,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              rdata_latched,
  input  logic              resp_latched,
  output logic              rdata_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              resp_valid,
  output logic [1:0]        response,
  output logic              mready,
  output logic              merror,
  output logic              mretry,
  output logic              busy
);

  assign busy = rdata_valid || resp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_valid <= 1'b0;
      rdata       <= '0;
      resp_valid  <= 1'b0;
      response    <= RS_OKAY;
      mready      <= 1'b0;
      merror      <= 1'b0;
      mretry      <= 1'b0;
    end else begin
      mready <= fin_ok;
      merror <= fin_err;
      mretry <= fin_again;

      if (fin_ok || fin_err) begin
        resp_valid <= 1'b1;
        response   <= fin_err ? RS_ERROR : RS_OKAY;
      end else if (resp_latched) begin
        resp_valid <= 1'b0;
      end

      if (fin_ok && fin_read) begin
        rdata_valid <= 1'b1;
        rdata       <= hrdata;
      end else if (rdata_latched) begin
        rdata_valid <= 1'b0;
      end
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $countones({mready, merror, mretry}) <= 1); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rdata_valid && !rdata_latched) |=> (rdata_valid && $stable(rdata))); // R7

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_latched) |=> (resp_valid && $stable(response))); // R8

  AST_ERR_NO_RDATA: assert property (@(posedge clk) disable iff (rst)
    merror |-> !rdata_valid); // R11

  AST_RETRY_SILENT: assert property (@(posedge clk) disable iff (rst)
    mretry |-> !resp_valid); // R10

endmodule

// File: rtl/ahb_cmd_master.sv
module ahb_cmd_master
  import ahbm_pkg::*;
#(
  parameter int         ADDR_W   = 32,
  parameter int         DATA_W   = 32,
  parameter logic [3:0] PROT_VAL = 4'b0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  output logic              cmd_latched,
  input  logic              wdata_valid,
  input  logic [DATA_W-1:0] wdata,
  output logic              wdata_latched,
  output logic              rdata_valid,
  output logic [DATA_W-1:0] rdata,
  input  logic              rdata_latched,
  output logic              resp_valid,
  output logic [1:0]        response,
  input  logic              resp_latched,
  output logic              mready,
  output logic              merror,
  output logic              mretry,
  output logic              hbusreq,
  input  logic              hgrant,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hburst,
  output logic [3:0]        hprot,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic [1:0]        hresp,
  input  logic [DATA_W-1:0] hrdata
);

  logic              take_cmd;
  logic              take_wd;
  logic              fin_ok;
  logic              fin_err;
  logic              fin_again;
  logic              ret_busy;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write;
  logic [DATA_W-1:0] cur_wdata;

  ahbm_cmd_stage #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) cmd_i (
    .clk           (clk),
    .rst           (rst),
    .take_cmd      (take_cmd),
    .take_wd       (take_wd),
    .cmd_addr      (cmd_addr),
    .cmd_write     (cmd_write),
    .wdata         (wdata),
    .cmd_latched   (cmd_latched),
    .wdata_latched (wdata_latched),
    .cur_addr      (cur_addr),
    .cur_write     (cur_write),
    .cur_wdata     (cur_wdata)
  );

  ahbm_bus_fsm #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PROT_VAL (PROT_VAL)
  ) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .wdata_valid (wdata_valid),
    .ret_busy    (ret_busy),
    .cur_addr    (cur_addr),
    .cur_write   (cur_write),
    .cur_wdata   (cur_wdata),
    .hgrant      (hgrant),
    .hready      (hready),
    .hresp       (hresp),
    .take_cmd    (take_cmd),
    .take_wd     (take_wd),
    .fin_ok      (fin_ok),
    .fin_err     (fin_err),
    .fin_again   (fin_again),
    .hbusreq     (hbusreq),
    .htrans      (htrans),
    .haddr       (haddr),
    .hwrite      (hwrite),
    .hburst      (hburst),
    .hprot       (hprot),
    .hwdata      (hwdata)
  );

  ahbm_ret_chan #(
    .DATA_W (DATA_W)
  ) ret_i (
    .clk           (clk),
    .rst           (rst),
    .fin_ok        (fin_ok),
    .fin_err       (fin_err),
    .fin_again     (fin_again),
    .fin_read      (!cur_write),
    .hrdata        (hrdata),
    .rdata_latched (rdata_latched),
    .resp_latched  (resp_latched),
    .rdata_valid   (rdata_valid),
    .rdata         (rdata),
    .resp_valid    (resp_valid),
    .response      (response),
    .mready        (mready),
    .merror        (merror),
    .mretry        (mretry),
    .busy          (ret_busy)
  );

endmodule

// File: tb/ahb_cmd_master_tb.sv
`timescale 1ns/1ps
module ahb_cmd_master_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct packed {
    logic          wr;
    logic [31:0]   addr;
    logic [31:0]   wd;
    logic [3:0]    gdly;
    logic [3:0]    ahold;
    logic [3:0]    waits;
    logic [1:0]    rsp;
    logic [31:0]   rd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h4000_0010, 32'hA5A5_0001, 4'd0, 4'd0, 4'd0, 2'b00, 32'h0},
    '{1'b0, 32'h4000_0020, 32'h0,         4'd2, 4'd0, 4'd3, 2'b00, 32'h1234_5678},
    '{1'b1, 32'h4000_0030, 32'hDEAD_BEEF, 4'd1, 4'd2, 4'd1, 2'b01, 32'h0},
    '{1'b0, 32'h4000_0040, 32'h0,         4'd0, 4'd1, 4'd0, 2'b10, 32'hCAFE_F00D},
    '{1'b1, 32'h4000_0050, 32'h0F0F_F0F0, 4'd3, 4'd0, 4'd2, 2'b10, 32'h0},
    '{1'b0, 32'h4000_0060, 32'h0,         4'd1, 4'd0, 4'd2, 2'b01, 32'h7777_1111},
    '{1'b0, 32'h4000_0070, 32'h0,         4'd0, 4'd0, 4'd1, 2'b11, 32'h0BAD_CAFE}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic          cmd_latched;
  logic          wdata_valid = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          wdata_latched;
  logic          rdata_valid;
  logic [DW-1:0] rdata;
  logic          rdata_latched = 1'b0;
  logic          resp_valid;
  logic [1:0]    response;
  logic          resp_latched = 1'b0;
  logic          mready, merror, mretry;
  logic          hbusreq;
  logic          hgrant = 1'b0;
  logic [1:0]    htrans;
  logic [AW-1:0] haddr;
  logic          hwrite;
  logic [2:0]    hburst;
  logic [3:0]    hprot;
  logic [DW-1:0] hwdata;
  logic          hready = 1'b1;
  logic [1:0]    hresp = 2'b00;
  logic [DW-1:0] hrdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ahb_cmd_master #(.ADDR_W(AW), .DATA_W(DW), .PROT_VAL(4'b0011)) dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_latched(cmd_latched),
    .wdata_valid(wdata_valid), .wdata(wdata), .wdata_latched(wdata_latched),
    .rdata_valid(rdata_valid), .rdata(rdata), .rdata_latched(rdata_latched),
    .resp_valid(resp_valid), .response(response), .resp_latched(resp_latched),
    .mready(mready), .merror(merror), .mretry(mretry),
    .hbusreq(hbusreq), .hgrant(hgrant), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
    .hburst(hburst), .hprot(hprot), .hwdata(hwdata),
    .hready(hready), .hresp(hresp), .hrdata(hrdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Offer a command and expect its acknowledge one cycle later.
  task automatic send_cmd(input vec_t v);
    cmd_valid = 1'b1; cmd_addr = v.addr; cmd_write = v.wr;
    @(negedge clk);
    chk("R2", "cmd_latched", cmd_latched, 1);
    cmd_valid = 1'b0;
    if (v.wr) begin
      chk("R3", "hbusreq before wdata", hbusreq, 0);
      wdata_valid = 1'b1; wdata = v.wd;
      @(negedge clk);
      chk("R3", "wdata_latched", wdata_latched, 1);
      wdata_valid = 1'b0; wdata = '0;
    end
    chk("R4", "hbusreq raised", hbusreq, 1);
  endtask

  // One bus attempt: grant, address phase, data phase, completion.
  task automatic bus_phase(input vec_t v, input logic [1:0] rc, input int waits);
    for (int i = 0; i < int'(v.gdly); i++) begin
      chk("R4", "hbusreq waiting", hbusreq, 1);
      chk("R4", "htrans before grant", htrans, 2'b00);
      @(negedge clk);
    end
    hgrant = 1'b1; hready = 1'b1;
    @(negedge clk);
    chk("R4", "htrans nonseq", htrans, 2'b10);
    chk("R5", "haddr", haddr, v.addr);
    chk("R5", "hwrite", hwrite, v.wr);
    chk("R5", "hburst", hburst, 3'b000);
    chk("R5", "hprot", hprot, 4'b0011);
    chk("R6", "hwdata in addr phase", hwdata, 0);
    hgrant = 1'b0;
    for (int i = 0; i < int'(v.ahold); i++) begin
      hready = 1'b0;
      @(negedge clk);
      chk("R5", "htrans held", htrans, 2'b10);
      chk("R5", "haddr held", haddr, v.addr);
    end
    hready = 1'b1;
    @(negedge clk);
    chk("R5", "htrans back idle", htrans, 2'b00);
    chk("R4", "hbusreq dropped", hbusreq, 0);
    chk("R6", "hwdata data phase", hwdata, v.wr ? v.wd : 32'h0);
    for (int i = 0; i < waits; i++) begin
      hready = 1'b0; hresp = 2'b00; hrdata = 32'hFFFF_FFFF;
      @(negedge clk);
      chk("R6", "hwdata in wait", hwdata, v.wr ? v.wd : 32'h0);
      chk("R8", "no early resp", resp_valid, 0);
    end
    if (rc != 2'b00) begin
      hready = 1'b0; hresp = rc; hrdata = 32'hFFFF_FFFF;
      @(negedge clk);
    end
    hready = 1'b1; hresp = rc; hrdata = v.rd;
    @(negedge clk);
    hresp = 2'b00; hrdata = '0;
    chk("R6", "hwdata after data", hwdata, 0);
  endtask

  task automatic drain();
    rdata_latched = rdata_valid; resp_latched = 1'b1;
    @(negedge clk);
    rdata_latched = 1'b0; resp_latched = 1'b0;
    chk("R8", "resp cleared", resp_valid, 0);
    chk("R7", "rdata cleared", rdata_valid, 0);
  endtask

  task automatic run_txn(input vec_t v);
    logic [1:0] fin;
    send_cmd(v);
    if (v.rsp[1]) begin
      bus_phase(v, v.rsp, int'(v.waits));
      chk("R9", "mretry pulse", mretry, 1);
      chk("R9", "no mready", mready, 0);
      chk("R10", "no resp on retry", resp_valid, 0);
      chk("R10", "no rdata on retry", rdata_valid, 0);
      chk("R10", "hbusreq again", hbusreq, 1);
      bus_phase(v, 2'b00, 0);
      fin = 2'b00;
    end else begin
      bus_phase(v, v.rsp, int'(v.waits));
      fin = v.rsp;
    end
    if (fin == 2'b00) begin
      chk("R9", "mready pulse", mready, 1);
      chk("R9", "no merror", merror, 0);
      chk("R8", "resp_valid", resp_valid, 1);
      chk("R8", "response okay", response, 2'b00);
      chk("R7", "rdata_valid", rdata_valid, !v.wr);
      if (!v.wr) chk("R7", "rdata value", rdata, v.rd);
    end else begin
      chk("R9", "merror pulse", merror, 1);
      chk("R9", "no mready", mready, 0);
      chk("R11", "response error", response, 2'b01);
      chk("R11", "no rdata on error", rdata_valid, 0);
    end
    @(negedge clk);
    chk("R9", "flags drop", {mready, merror, mretry}, 3'b000);
    chk("R8", "resp held", resp_valid, 1);
    chk("R11", "no further request", hbusreq, 0);
    chk("R11", "no further transfer", htrans, 2'b00);
    drain();
  endtask

  initial begin
    vec_t vr;
    vec_t vn;
    repeat (3) @(negedge clk);
    chk("R1", "htrans in reset", htrans, 2'b00);
    chk("R1", "hbusreq in reset", hbusreq, 0);
    chk("R1", "hwdata in reset", hwdata, 0);
    chk("R1", "core outs in reset",
        {cmd_latched, wdata_latched, rdata_valid, resp_valid, mready, merror, mretry}, 7'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "idle after reset", {hbusreq, htrans, hwdata != 0}, 4'd0);

    for (int k = 0; k < NV; k++) run_txn(VECS[k]);

    // wdata_valid with no write pending is ignored.
    wdata_valid = 1'b1; wdata = 32'h5555_AAAA;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3", "stray wdata ignored", wdata_latched, 0);
      chk("R3", "no request on stray wdata", hbusreq, 0);
    end
    wdata_valid = 1'b0;

    // Channels drain independently; new command waits for both.
    vr = VECS[1]; vr.gdly = 4'd0; vr.waits = 4'd0;
    send_cmd(vr);
    bus_phase(vr, 2'b00, 0);
    resp_latched = 1'b1;
    @(negedge clk);
    resp_latched = 1'b0;
    chk("R8", "resp drained alone", resp_valid, 0);
    chk("R8", "rdata still held", rdata_valid, 1);
    vn = VECS[3]; vn.rd = 32'h0246_8ACE;
    cmd_valid = 1'b1; cmd_addr = vn.addr; cmd_write = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "cmd blocked by rdata", cmd_latched, 0);
      chk("R7", "rdata value held", rdata, vr.rd);
    end
    rdata_latched = 1'b1;
    @(negedge clk);
    rdata_latched = 1'b0;
    chk("R7", "rdata drained", rdata_valid, 0);
    chk("R2", "not yet taken", cmd_latched, 0);
    @(negedge clk);
    chk("R2", "cmd taken after drain", cmd_latched, 1);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R2", "cmd pulse one cycle", cmd_latched, 0);
    bus_phase(vn, 2'b00, 0);
    chk("R7", "second rdata", rdata, 32'h0246_8ACE);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule